// File: doc/BRIEF.md
# Segment-Truncating Approximate Multiplier

This block multiplies two unsigned 16-bit operands and returns an approximate 32-bit product in a single combinational pass. Each operand is cut down to one 8-bit window. The two windows are multiplied by a small shift-and-add core that has no hard multiplier: one gated row per control bit, then the rows are summed. The 16-bit partial product is then shifted left by the sum of the offsets at which the two windows were cut.

A mode pin picks how each window is cut. In the cheap static mode, a single OR over the upper byte decides between the upper byte and the lower byte. In the dynamic mode, the window starts at the operand's most significant 1 and runs downward, so a large operand keeps its most significant bits whatever its magnitude. A separate enhance pin adds one to the second operand's window when that window is below 15. This reduces the bias that truncation puts on small windows.

The block suits error-tolerant pixel and filter arithmetic, where an accurate full-width multiplier would cost too much area or delay.

Top module: `approx_seg_mul`

## Requirements
- R1: In static mode (`sel_dyn`=0), an operand with any 1 in bits 15..8 contributes its bits 15..8 as its window with a shift of 8. Otherwise it contributes bits 7..0 with a shift of 0.
- R2: In dynamic mode (`sel_dyn`=1), an operand whose highest set bit k is 8 or more contributes bits k..k-7 with a shift of k-7. An operand below 256 contributes bits 7..0 with a shift of 0.
- R3: `product` equals the product of the two 8-bit windows, shifted left by the sum of the two shifts and kept to 32 bits.
- R4: With `enh_en`=1, a window of operand B whose value is 14 or less is raised by one before multiplying. Windows of 15 or more are used unchanged, and operand A's window is never altered.
- R5: If either operand is zero, `product` is zero in every mode, including with `enh_en`=1.
- R6: With `enh_en`=0 and both operands below 256, `product` is the exact product in both modes.
- R7: With `enh_en`=0, `product` never exceeds the exact product.
- R8: In dynamic mode with `enh_en`=0, `product` is never smaller than 63/64 of the exact product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 16 | Multiplicand, unsigned |
| op_b | input | 16 | Multiplier, unsigned; its window receives the enhance correction |
| sel_dyn | input | 1 | 0 = static window selection by high-byte OR, 1 = dynamic selection by leading one |
| enh_en | input | 1 | 1 = add one to a B window whose value is below 15 |
| product | output | 32 | Approximate unsigned product |

## Verification
The checker evaluates its properties every time the inputs change, so it assumes the four inputs are driven to known 0/1 values and held long enough for the combinational path to settle. The bench meets this by changing the inputs only after a falling clock edge and reading `product` one nanosecond later. The error-bound and no-overshoot properties hold only with the enhance pin low. For that reason they are qualified by `enh_en`. The stimulus spends many vectors in each of the four mode and enhance combinations, and it draws operand widths at random so that every leading-one position from 0 to 15 is reached.

// File: rtl/seg_mul_pkg.sv
package seg_mul_pkg;

    localparam int OP_W    = 16;
    localparam int SEG_W   = 8;
    localparam int PROD_W  = 2 * OP_W;
    localparam int CORE_W  = 2 * SEG_W;
    localparam int MAX_SH  = OP_W - SEG_W;
    localparam int SH_W    = $clog2(MAX_SH + 1);
    localparam int TOT_W   = SH_W + 1;
    localparam int LEAD_W  = $clog2(OP_W);
    localparam int BIAS_LT = 15;

    typedef enum logic {
        SEL_STATIC  = 1'b0,
        SEL_DYNAMIC = 1'b1
    } sel_mode_e;

    typedef struct packed {
        logic [SEG_W-1:0] seg;
        logic [SH_W-1:0]  sh;
    } seg_pick_t;

    function automatic logic [LEAD_W-1:0] top_one_idx(input logic [OP_W-1:0] v);
        logic [LEAD_W-1:0] idx;
        idx = '0;
        for (int i = 0; i < OP_W; i++) begin
            if (v[i]) idx = LEAD_W'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/seg_window_pick.sv
module seg_window_pick
    import seg_mul_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  sel_mode_e       mode,
    output seg_pick_t       pick
);

    logic              upper_any;
    logic [LEAD_W-1:0] lead;
    logic [SH_W-1:0]   sh;
    logic [OP_W-1:0]   moved;

    always_comb begin
        upper_any = |op[OP_W-1:SEG_W];
        lead      = top_one_idx(op);
        if (!upper_any) begin
            sh = '0;
        end else if (mode == SEL_STATIC) begin
            sh = SH_W'(MAX_SH);
        end else begin
            sh = SH_W'(lead - LEAD_W'(SEG_W - 1));
        end
        moved    = op >> sh;
        pick.seg = moved[SEG_W-1:0];
        pick.sh  = sh;
    end

endmodule

// File: rtl/seg_small_bias.sv
module seg_small_bias
    import seg_mul_pkg::*;
(
    input  logic [SEG_W-1:0] seg_in,
    input  logic             bias_en,
    output logic [SEG_W-1:0] seg_out
);

    always_comb begin
        if (bias_en && (seg_in < SEG_W'(BIAS_LT))) seg_out = seg_in + SEG_W'(1);
        else                                         seg_out = seg_in;
    end

endmodule

// File: rtl/shift_add_core.sv
module shift_add_core
    import seg_mul_pkg::*;
(
    input  logic [SEG_W-1:0]  mcand,
    input  logic [SEG_W-1:0]  ctrl,
    output logic [CORE_W-1:0] prod
);

    logic [CORE_W-1:0] row [SEG_W];

    for (genvar g = 0; g < SEG_W; g++) begin : g_row
        assign row[g] = ctrl[g] ? (CORE_W'(mcand) << g) : '0;
    end

    always_comb begin
        prod = '0;
        for (int i = 0; i < SEG_W; i++) prod = prod + row[i];
    end

endmodule

// File: rtl/approx_seg_mul.sv
module approx_seg_mul
    import seg_mul_pkg::*;
(
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    input  logic              sel_dyn,
    input  logic              enh_en,
    output logic [PROD_W-1:0] product
);

    sel_mode_e         mode;
    seg_pick_t         pick_a;
    seg_pick_t         pick_b;
    logic [SEG_W-1:0]  ctrl_seg;
    logic [CORE_W-1:0] core_p;
    logic [TOT_W-1:0]  sh_tot;
    logic              zero_in;

    assign mode = sel_mode_e'(sel_dyn);

    seg_window_pick u_pick_a (.op(op_a), .mode(mode), .pick(pick_a));
    seg_window_pick u_pick_b (.op(op_b), .mode(mode), .pick(pick_b));

    seg_small_bias u_bias (
        .seg_in  (pick_b.seg),
        .bias_en (enh_en),
        .seg_out (ctrl_seg)
    );

    shift_add_core u_core (
        .mcand (pick_a.seg),
        .ctrl  (ctrl_seg),
        .prod  (core_p)
    );

    always_comb begin
        zero_in = (op_a == '0) || (op_b == '0);
        sh_tot  = TOT_W'(pick_a.sh) + TOT_W'(pick_b.sh);
        product = zero_in ? '0 : (PROD_W'(core_p) << sh_tot);
    end

endmodule

// File: rtl/approx_seg_mul_chk.sv
module approx_seg_mul_chk
    import seg_mul_pkg::*;
(
    input logic [OP_W-1:0]   op_a,
    input logic [OP_W-1:0]   op_b,
    input logic              sel_dyn,
    input logic              enh_en,
    input logic [PROD_W-1:0] product
);

    logic [63:0] exact;
    logic [63:0] approx;

    always_comb begin
        exact  = 64'(op_a) * 64'(op_b);
        approx = 64'(product);

        assert_zero_operand_R5: assert (!((op_a == '0) || (op_b == '0)) || (product == '0))
            else $error("R5 zero operand gave nonzero product");

        assert_small_exact_R6: assert (!(!enh_en && op_a < 16'd256 && op_b < 16'd256) || (approx == exact))
            else $error("R6 small operands not exact");

        assert_no_overshoot_R7: assert (enh_en || (approx <= exact))
            else $error("R7 product above exact");

        assert_dyn_bound_R8: assert (!(sel_dyn && !enh_en) || ((approx << 6) >= (exact * 64'd63)))
            else $error("R8 dynamic error bound broken");

        assert_static_low_zero_R1: assert (!(!sel_dyn && (op_a[OP_W-1:SEG_W] != '0)) || (product[SEG_W-1:0] == '0))
            else $error("R1 static upper window left low bits");

        assert_bias_small_R4: assert (!(enh_en && op_a < 16'd256 && op_b != '0 && op_b < 16'd15)
                                      || (approx == 64'(op_a) * (64'(op_b) + 64'd1)))
            else $error("R4 small B window not incremented");
    end

endmodule

bind approx_seg_mul approx_seg_mul_chk u_chk (
    .op_a    (op_a),
    .op_b    (op_b),
    .sel_dyn (sel_dyn),
    .enh_en  (enh_en),
    .product (product)
);

// File: tb/tb_approx_seg_mul.sv
`timescale 1ns/1ps
module tb_approx_seg_mul;

    logic        clk = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        sel_dyn = 1'b0;
    logic        enh_en = 1'b0;
    logic [31:0] product;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;
    real worst_st = 0.0;
    real worst_dy = 0.0;

    always #4 clk = ~clk;

    approx_seg_mul dut (
        .op_a(op_a), .op_b(op_b), .sel_dyn(sel_dyn), .enh_en(enh_en), .product(product)
    );

    function automatic longint unsigned ref_mul(int unsigned a, int unsigned b, bit dyn, bit enh);
        int unsigned sa = a;
        int unsigned sb = b;
        int unsigned ka = 0;
        int unsigned kb = 0;
        if (a == 0 || b == 0) return 0;
        if (dyn) begin
            while (sa > 255) begin sa = sa >> 1; ka++; end
            while (sb > 255) begin sb = sb >> 1; kb++; end
        end else begin
            if (sa > 255) begin sa = sa / 256; ka = 8; end
            if (sb > 255) begin sb = sb / 256; kb = 8; end
        end
        if (enh && sb < 15) sb++;
        return ((longint'(sa) * longint'(sb)) << (ka + kb)) & 64'hFFFF_FFFF;
    endfunction

    task automatic apply(input int unsigned a, input int unsigned b, input bit dyn, input bit enh);
        @(negedge clk);
        op_a = 16'(a); op_b = 16'(b); sel_dyn = dyn; enh_en = enh;
        #1;
    endtask

    task automatic check(input int unsigned a, input int unsigned b, input bit dyn, input bit enh,
                         input longint unsigned expv, input string req);
        apply(a, b, dyn, enh);
        n_chk++;
        if (longint'(product) != expv) begin
            n_fail++;
            $display("FAIL %s a=%0d b=%0d dyn=%0d enh=%0d actual=%0d expected=%0d",
                     req, a, b, dyn, enh, product, expv);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // idle state: zero inputs give zero (R5)
        check(0, 0, 0, 0, 0, "R5");
        // R6 exact small operands
        check(200, 255, 0, 0, 51000, "R6");
        check(200, 255, 1, 0, 51000, "R6");
        // R1 static: upper byte of A, low byte of B
        check(16'h1234, 16'h0056, 0, 0, 396288, "R1");
        // R2 dynamic: window a[12:5]=145, shift 5
        check(16'h1234, 16'h0056, 1, 0, 399040, "R2");
        // R3 both shifted by 8
        check(16'hFFFF, 16'hFFFF, 0, 0, 64'd4261478400, "R3");
        check(16'hFFFF, 16'hFFFF, 1, 0, 64'd4261478400, "R3");
        // R4 enhance
        check(100, 10, 0, 1, 1100, "R4");
        check(100, 14, 0, 1, 1500, "R4");
        check(100, 15, 0, 1, 1500, "R4");
        check(10, 100, 0, 1, 1000, "R4");
        check(3, 16'h0E00, 0, 1, 11520, "R4");
        check(3, 16'h0E00, 0, 0, 10752, "R4");
        check(3, 16'h0700, 1, 1, 3 * 224 * 8, "R4");
        // R5 zero with enhance
        check(500, 0, 0, 1, 0, "R5");
        check(0, 5, 1, 1, 0, "R5");

        // R3 R7 R8 random sweep against the model in every mode
        for (int m = 0; m < 4; m++) begin
            for (int i = 0; i < 3000; i++) begin
                int unsigned a = $urandom & ((32'd1 << ($urandom % 17)) - 1);
                int unsigned b = $urandom & ((32'd1 << ($urandom % 17)) - 1);
                bit dyn = m[0];
                bit enh = m[1];
                longint unsigned e = ref_mul(a, b, dyn, enh);
                check(a, b, dyn, enh, e, "R3");
                if (!enh && a != 0 && b != 0) begin
                    real ex = real'(a) * real'(b);
                    real err = (ex - real'(product)) / ex;
                    if (dyn) begin if (err > worst_dy) worst_dy = err; end
                    else     begin if (err > worst_st) worst_st = err; end
                    n_chk++;
                    if (longint'(product) > longint'(a) * longint'(b)) begin
                        n_fail++;
                        $display("FAIL R7 a=%0d b=%0d actual=%0d expected<=%0d",
                                 a, b, product, longint'(a) * longint'(b));
                    end
                end
            end
        end

        $display("worst relative error: static %f dynamic %f", worst_st, worst_dy);
        n_chk++;
        if (worst_dy > 1.0 / 64.0) begin
            n_fail++;
            $display("FAIL R8 actual=%f expected<=%f", worst_dy, 1.0 / 64.0);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule